// File: doc/BRIEF.md
# Interrupt Routing and Power-Change Control Register

This block is a 32-bit configuration register for a bridge that exposes two functions. It sits at configuration offset 80h in both functions and resets to 0844_9060h. Some fields are shared between the functions and some are held once per function. The register settings decide how four raw interrupt requests (A, B, C, D) reach four output interrupt slots. Requests can be merged onto request A, and the slot assignment can be rotated. The block also reports the interrupt pin that each function advertises.

The same register handles power-change notification. When management-interrupt mode is on, a write to a socket's power control sets a sticky status flag for that socket. While the flag is set, a request is raised either on the IRQ2 line or on that socket's card-status-change line, depending on a shared routing field. Software clears the flag by writing 1 to it.

Top module: `sysctl_irq_route`

## Requirements
- R1: Offset 80h reads 0844_9060h in both functions after global reset. Any other offset reads 0.
- R2: Bits 31:30 are the rotation step s. Merged request i (A=0, B=1, C=2, D=3) drives slot (i+s) mod 4 on `slot_irq` (bit 0 = slot A). For example, s=01 puts A on slot B.
- R3: Bit 29 ORs request B into A and forces B to 0. It leaves C and D alone. While bit 29 is set, `int_pin[15:8]` (function 1) reports 01h instead of 02h. `int_pin[7:0]` (function 0) always reports 01h.
- R4: Bit 28 is held per function. If either function's copy is set, the OR of all four requests drives merged A and the other merged requests are 0. This takes priority over bit 29, and function 1 then reports pin 01h. Merging is applied before rotation.
- R5: A pulse on `pwr_wr[k]` sets bit 25 of function k only while shared bit 24 is 1. With bit 24 at 0, the pulse has no effect.
- R6: Writing 1 to bit 25 clears it, and writing 0 leaves it unchanged. If a strobe and a clear land in the same cycle, the flag ends up set.
- R7: Shared bit 26 selects the destination for the flags. With bit 26 at 0, `irq2_req` is high while any flag is set. With bit 26 at 1, `csc_req[k]` follows flag k and `irq2_req` stays low.
- R8: Bits 31:30, 29, 26 and 24 are shared. Only function 0 can write them, and both functions read the same value. Writes to these bits from function 1 are ignored.
- R9: A synchronous function reset (`frst_n[k]` low at a clock edge) returns function k's writable bits 23:0 to their defaults. It leaves bits 31:24 alone. Global reset restores the whole register.
- R10: Only byte lanes whose `cfg_be` bit is set are written (bit j covers bits 8j+7:8j). Read-only bits ignore writes and read their defaults: bits 18 and 12 read 1, and bit 23 and the other read-only bits read 0.
- R11: `slot_irq` is registered. It shows the routing of the inputs present at the previous rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| grst_n | input | 1 | Global reset, active low, asynchronous |
| frst_n | input | NUM_FN | Per-function reset, active low, synchronous |
| cfg_wr | input | 1 | Register write strobe |
| cfg_fn | input | FN_W | Function index for reads and writes |
| cfg_addr | input | ADDR_W | Configuration offset |
| cfg_be | input | 4 | Byte enables for the write |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data for cfg_fn / cfg_addr (combinational) |
| irq_req | input | 4 | Raw requests A..D (bit 0 = A) |
| pwr_wr | input | NUM_FN | Socket power-control write strobe, one per socket |
| slot_irq | output | 4 | Routed slot interrupts (bit 0 = slot A) |
| int_pin | output | 8*NUM_FN | Reported interrupt pin per function, 8 bits each |
| irq2_req | output | 1 | Power-change request on IRQ2 |
| csc_req | output | NUM_FN | Per-socket card-status-change request |

## Verification
The hardest case to reach is a socket flag that is already set and receives its power strobe and a write-1-to-clear in the same clock. The bench gets there with a single write task that raises the strobe in the same cycle as the clear, after an earlier pulse has armed the flag. It then confirms that the flag holds and that writing 0 to it does nothing. A second hard case is the interplay of the per-function tie-all copy with the shared fields. To reach it, function 1 writes all ones to the top byte. The bench then watches the routing change while function 0's view of the shared fields stays the same.

// File: rtl/sysctl_pkg.sv
`timescale 1ns/1ps
package sysctl_pkg;
    localparam int REG_W  = 32;
    localparam int BE_W   = REG_W / 8;
    localparam int N_SLOT = 4;
    localparam int STEP_W = 2;

    localparam int BIT_STEP_LO = 30;
    localparam int BIT_PAIR    = 29;
    localparam int BIT_ALL     = 28;
    localparam int BIT_CSC     = 26;
    localparam int BIT_FLAG    = 25;
    localparam int BIT_EN      = 24;

    localparam logic [REG_W-1:0] RESET_WORD = 32'h0844_9060;
    localparam logic [REG_W-1:0] WRITABLE   = 32'hFF70_C07B;
    localparam logic [REG_W-1:0] SHARED     = 32'hE500_0000;
    localparam logic [REG_W-1:0] GRST_ONLY  = 32'hFF00_0000;
    localparam logic [REG_W-1:0] FLAG_MASK  = REG_W'(1) << BIT_FLAG;
    localparam logic [REG_W-1:0] FIXED_RO   = RESET_WORD & ~WRITABLE;
    localparam logic [REG_W-1:0] PER_FN     = WRITABLE & ~SHARED;
    localparam logic [REG_W-1:0] PLAIN_RW   = PER_FN & ~FLAG_MASK;

    typedef struct packed {
        logic [STEP_W-1:0] step;
        logic              pair_tie;
        logic              route_csc;
        logic              smi_en;
    } shared_cfg_t;

    function automatic logic [REG_W-1:0] be_to_mask(input logic [BE_W-1:0] be);
        logic [REG_W-1:0] m;
        m = '0;
        for (int b = 0; b < BE_W; b++) begin
            m[b*8 +: 8] = {8{be[b]}};
        end
        return m;
    endfunction
endpackage

// File: rtl/sysctl_regfile.sv
`timescale 1ns/1ps
module sysctl_regfile
    import sysctl_pkg::*;
#(
    parameter int               NUM_FN     = 2,
    parameter int               FN_W       = 1,
    parameter int               ADDR_W     = 8,
    parameter logic [ADDR_W-1:0] REG_OFFSET = 'h80
) (
    input  logic                clk,
    input  logic                grst_n,
    input  logic [NUM_FN-1:0]   frst_n,
    input  logic                wr_en,
    input  logic [FN_W-1:0]     acc_fn,
    input  logic [ADDR_W-1:0]   acc_addr,
    input  logic [BE_W-1:0]     wr_be,
    input  logic [REG_W-1:0]    wr_data,
    input  logic [NUM_FN-1:0]   pwr_wr,
    output logic [REG_W-1:0]    rd_data,
    output shared_cfg_t         cfg,
    output logic [NUM_FN-1:0]   all_tie,
    output logic [NUM_FN-1:0]   smi_flag
);
    typedef struct packed {
        logic [REG_W-1:0]             shr;
        logic [NUM_FN-1:0][REG_W-1:0] own;
    } regs_t;

    regs_t            st_d, st_q;
    logic             wr_hit;
    logic [REG_W-1:0] wmask;

    assign wr_hit = wr_en && (acc_addr == REG_OFFSET);
    assign wmask  = be_to_mask(wr_be);

    // next-state: shared fields (function 0 only), per-function fields, flag set/clear
    always_comb begin
        st_d = st_q;
        if (wr_hit && (acc_fn == '0)) begin
            st_d.shr = (st_q.shr & ~(wmask & SHARED)) | (wr_data & wmask & SHARED);
        end
        for (int f = 0; f < NUM_FN; f++) begin
            if (wr_hit && (acc_fn == FN_W'(f))) begin
                st_d.own[f] = (st_q.own[f] & ~(wmask & PLAIN_RW)) | (wr_data & wmask & PLAIN_RW);
                if (wmask[BIT_FLAG] && wr_data[BIT_FLAG]) begin
                    st_d.own[f][BIT_FLAG] = 1'b0;
                end
            end
            // set has priority over write-1-to-clear
            if (pwr_wr[f] && st_q.shr[BIT_EN]) begin
                st_d.own[f][BIT_FLAG] = 1'b1;
            end
            // function reset spares the upper byte
            if (!frst_n[f]) begin
                st_d.own[f] = (st_d.own[f] & GRST_ONLY) | (RESET_WORD & PER_FN & ~GRST_ONLY);
            end
        end
    end

    always_ff @(posedge clk or negedge grst_n) begin
        if (!grst_n) begin
            st_q.shr <= RESET_WORD & SHARED;
            for (int f = 0; f < NUM_FN; f++) begin
                st_q.own[f] <= RESET_WORD & PER_FN;
            end
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        rd_data = '0;
        for (int f = 0; f < NUM_FN; f++) begin
            if (acc_fn == FN_W'(f)) begin
                rd_data = (st_q.shr & SHARED) | (st_q.own[f] & PER_FN) | FIXED_RO;
            end
        end
        if (acc_addr != REG_OFFSET) begin
            rd_data = '0;
        end
    end

    assign cfg.step      = st_q.shr[BIT_STEP_LO +: STEP_W];
    assign cfg.pair_tie  = st_q.shr[BIT_PAIR];
    assign cfg.route_csc = st_q.shr[BIT_CSC];
    assign cfg.smi_en    = st_q.shr[BIT_EN];

    for (genvar f = 0; f < NUM_FN; f++) begin : g_fn_out
        assign all_tie[f]  = st_q.own[f][BIT_ALL];
        assign smi_flag[f] = st_q.own[f][BIT_FLAG];
    end
endmodule

// File: rtl/sysctl_int_router.sv
`timescale 1ns/1ps
module sysctl_int_router
    import sysctl_pkg::*;
#(
    parameter int NUM_FN = 2
) (
    input  logic              clk,
    input  logic              grst_n,
    input  logic [N_SLOT-1:0] req,
    input  logic [STEP_W-1:0] step,
    input  logic              pair_tie,
    input  logic [NUM_FN-1:0] all_tie,
    output logic [N_SLOT-1:0] slot
);
    typedef struct packed {
        logic [N_SLOT-1:0] slot;
    } rt_t;

    rt_t               rt_d, rt_q;
    logic [N_SLOT-1:0] merged;

    // merge first, then rotate
    always_comb begin
        merged = req;
        if (|all_tie) begin
            merged = {{(N_SLOT-1){1'b0}}, |req};
        end else if (pair_tie) begin
            merged[0] = req[0] | req[1];
            merged[1] = 1'b0;
        end
        rt_d.slot = '0;
        for (int i = 0; i < N_SLOT; i++) begin
            rt_d.slot[(i + int'(step)) % N_SLOT] = merged[i];
        end
    end

    always_ff @(posedge clk or negedge grst_n) begin
        if (!grst_n) begin
            rt_q <= '0;
        end else begin
            rt_q <= rt_d;
        end
    end

    assign slot = rt_q.slot;
endmodule

// File: rtl/sysctl_pin_report.sv
`timescale 1ns/1ps
module sysctl_pin_report #(
    parameter int NUM_FN = 2
) (
    input  logic                  pair_tie,
    input  logic [NUM_FN-1:0]     all_tie,
    output logic [8*NUM_FN-1:0]   pin_code
);
    for (genvar f = 0; f < NUM_FN; f++) begin : g_pin
        if (f == 0) begin : g_first
            assign pin_code[7:0] = 8'h01;
        end else if (f == 1) begin : g_second
            assign pin_code[15:8] = ((|all_tie) || pair_tie) ? 8'h01 : 8'h02;
        end else begin : g_rest
            assign pin_code[f*8 +: 8] = (|all_tie) ? 8'h01 : 8'(f + 1);
        end
    end
endmodule

// File: rtl/sysctl_smi_route.sv
`timescale 1ns/1ps
module sysctl_smi_route #(
    parameter int NUM_FN = 2
) (
    input  logic [NUM_FN-1:0] smi_flag,
    input  logic              route_csc,
    output logic              irq2,
    output logic [NUM_FN-1:0] csc
);
    always_comb begin
        irq2 = 1'b0;
        csc  = '0;
        if (route_csc) begin
            csc = smi_flag;
        end else begin
            irq2 = |smi_flag;
        end
    end
endmodule

// File: rtl/sysctl_irq_route.sv
`timescale 1ns/1ps
module sysctl_irq_route
    import sysctl_pkg::*;
#(
    parameter int                NUM_FN     = 2,
    parameter int                FN_W       = (NUM_FN > 1) ? $clog2(NUM_FN) : 1,
    parameter int                ADDR_W     = 8,
    parameter logic [ADDR_W-1:0] REG_OFFSET = 'h80
) (
    input  logic                 clk,
    input  logic                 grst_n,
    input  logic [NUM_FN-1:0]    frst_n,
    input  logic                 cfg_wr,
    input  logic [FN_W-1:0]      cfg_fn,
    input  logic [ADDR_W-1:0]    cfg_addr,
    input  logic [3:0]           cfg_be,
    input  logic [31:0]          cfg_wdata,
    output logic [31:0]          cfg_rdata,
    input  logic [3:0]           irq_req,
    input  logic [NUM_FN-1:0]    pwr_wr,
    output logic [3:0]           slot_irq,
    output logic [8*NUM_FN-1:0]  int_pin,
    output logic                 irq2_req,
    output logic [NUM_FN-1:0]    csc_req
);
    shared_cfg_t       shr_cfg;
    logic [NUM_FN-1:0] all_tie;
    logic [NUM_FN-1:0] smi_flag;

    sysctl_regfile #(
        .NUM_FN(NUM_FN), .FN_W(FN_W), .ADDR_W(ADDR_W), .REG_OFFSET(REG_OFFSET)
    ) regs_i (
        .clk(clk), .grst_n(grst_n), .frst_n(frst_n),
        .wr_en(cfg_wr), .acc_fn(cfg_fn), .acc_addr(cfg_addr),
        .wr_be(cfg_be), .wr_data(cfg_wdata), .pwr_wr(pwr_wr),
        .rd_data(cfg_rdata), .cfg(shr_cfg), .all_tie(all_tie), .smi_flag(smi_flag)
    );

    sysctl_int_router #(.NUM_FN(NUM_FN)) router_i (
        .clk(clk), .grst_n(grst_n), .req(irq_req),
        .step(shr_cfg.step), .pair_tie(shr_cfg.pair_tie), .all_tie(all_tie),
        .slot(slot_irq)
    );

    sysctl_pin_report #(.NUM_FN(NUM_FN)) pins_i (
        .pair_tie(shr_cfg.pair_tie), .all_tie(all_tie), .pin_code(int_pin)
    );

    sysctl_smi_route #(.NUM_FN(NUM_FN)) smi_i (
        .smi_flag(smi_flag), .route_csc(shr_cfg.route_csc),
        .irq2(irq2_req), .csc(csc_req)
    );
endmodule

// File: rtl/sysctl_irq_route_chk.sv
`timescale 1ns/1ps
module sysctl_irq_route_chk #(
    parameter int NUM_FN = 2,
    parameter int FN_W   = 1
) (
    input logic              clk,
    input logic              grst_n,
    input logic [NUM_FN-1:0] frst_n,
    input logic              cfg_wr,
    input logic [FN_W-1:0]   cfg_fn,
    input logic [3:0]        irq_req,
    input logic [NUM_FN-1:0] pwr_wr,
    input logic [3:0]        slot_irq,
    input logic [1:0]        step,
    input logic              pair_tie,
    input logic [NUM_FN-1:0] all_tie,
    input logic              smi_en,
    input logic              route_csc,
    input logic [NUM_FN-1:0] smi_flag
);
    logic [4:0] shared_vec;
    assign shared_vec = {step, pair_tie, route_csc, smi_en};

    assert_pass_through_R2: assert property (@(posedge clk) disable iff (!grst_n)
        ($past(grst_n) && !$past(|all_tie) && !$past(pair_tie) && ($past(step) == 2'd0))
        |-> (slot_irq == $past(irq_req)));

    assert_pair_merge_R3: assert property (@(posedge clk) disable iff (!grst_n)
        ($past(grst_n) && !$past(|all_tie) && $past(pair_tie) && ($past(step) == 2'd0))
        |-> (!slot_irq[1] && (slot_irq[0] == ($past(irq_req[0]) | $past(irq_req[1])))
             && (slot_irq[3:2] == $past(irq_req[3:2]))));

    assert_tie_all_single_R4: assert property (@(posedge clk) disable iff (!grst_n)
        ($past(grst_n) && $past(|all_tie)) |-> $onehot0(slot_irq));

    assert_flag_set_R5: assert property (@(posedge clk) disable iff (!grst_n)
        ($past(grst_n) && $past(pwr_wr[0]) && $past(smi_en)) |-> smi_flag[0]);

    assert_flag_sticky_R6: assert property (@(posedge clk) disable iff (!grst_n)
        ($past(grst_n) && $past(smi_flag[0]) && !$past(cfg_wr)) |-> smi_flag[0]);

    assert_shared_fn1_R8: assert property (@(posedge clk) disable iff (!grst_n)
        ($past(grst_n) && $past(cfg_wr) && ($past(cfg_fn) == FN_W'(1)))
        |-> (shared_vec == $past(shared_vec)));

    assert_frst_keeps_top_R9: assert property (@(posedge clk) disable iff (!grst_n)
        ($past(grst_n) && !$past(cfg_wr) && !$past(frst_n[0]))
        |-> ((shared_vec == $past(shared_vec)) && (all_tie[0] == $past(all_tie[0]))));
endmodule

bind sysctl_irq_route sysctl_irq_route_chk #(.NUM_FN(NUM_FN), .FN_W(FN_W)) chk_i (
    .clk(clk), .grst_n(grst_n), .frst_n(frst_n), .cfg_wr(cfg_wr), .cfg_fn(cfg_fn),
    .irq_req(irq_req), .pwr_wr(pwr_wr), .slot_irq(slot_irq),
    .step(shr_cfg.step), .pair_tie(shr_cfg.pair_tie), .all_tie(all_tie),
    .smi_en(shr_cfg.smi_en), .route_csc(shr_cfg.route_csc), .smi_flag(smi_flag)
);

// File: tb/sysctl_irq_route_tb.sv
`timescale 1ns/1ps
module sysctl_irq_route_tb_top;
    logic        clk = 1'b0;
    logic        grst_n = 1'b0;
    logic [1:0]  frst_n = 2'b11;
    logic        cfg_wr = 1'b0;
    logic [0:0]  cfg_fn = 1'b0;
    logic [7:0]  cfg_addr = 8'h80;
    logic [3:0]  cfg_be = 4'h0;
    logic [31:0] cfg_wdata = 32'h0;
    logic [31:0] cfg_rdata;
    logic [3:0]  irq_req = 4'h0;
    logic [1:0]  pwr_wr = 2'b00;
    logic [3:0]  slot_irq;
    logic [15:0] int_pin;
    logic        irq2_req;
    logic [1:0]  csc_req;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    sysctl_irq_route dut_i (
        .clk(clk), .grst_n(grst_n), .frst_n(frst_n), .cfg_wr(cfg_wr), .cfg_fn(cfg_fn),
        .cfg_addr(cfg_addr), .cfg_be(cfg_be), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .irq_req(irq_req), .pwr_wr(pwr_wr), .slot_irq(slot_irq), .int_pin(int_pin),
        .irq2_req(irq2_req), .csc_req(csc_req)
    );

    task automatic check32(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    // expected slot vector from the requirements: merge, then rotate left by step
    function automatic logic [3:0] exp_slot(input logic [3:0] r, input int s, input bit pair, input bit all);
        logic [3:0] m;
        logic [7:0] dbl;
        m = r;
        if (all) m = {3'b000, (r != 4'h0)};
        else if (pair) m = {r[3:2], 1'b0, r[1] | r[0]};
        dbl = {m, m} << s;
        return dbl[7:4];
    endfunction

    task automatic reg_wr(input bit fn, input logic [3:0] be, input logic [31:0] data, input logic [1:0] strobe);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_fn = fn; cfg_addr = 8'h80; cfg_be = be; cfg_wdata = data; pwr_wr = strobe;
        @(negedge clk);
        cfg_wr = 1'b0; cfg_be = 4'h0; pwr_wr = 2'b00;
    endtask

    task automatic top_wr(input bit fn, input logic [7:0] b);
        reg_wr(fn, 4'b1000, {b, 24'h0}, 2'b00);
    endtask

    task automatic rd_chk(input bit fn, input logic [7:0] addr, input logic [31:0] exp, input string tag);
        cfg_fn = fn; cfg_addr = addr;
        #1;
        check32(tag, cfg_rdata, exp);
        cfg_addr = 8'h80;
    endtask

    task automatic pwr_pulse(input logic [1:0] m);
        @(negedge clk); pwr_wr = m;
        @(negedge clk); pwr_wr = 2'b00;
    endtask

    task automatic slot_chk(input logic [3:0] r, input logic [3:0] exp, input string tag);
        @(negedge clk); irq_req = r;
        @(negedge clk);
        check32(tag, {28'h0, slot_irq}, {28'h0, exp});
    endtask

    task automatic t_reset;
        rd_chk(1'b0, 8'h80, 32'h0844_9060, "R1 fn0 reset value");
        rd_chk(1'b1, 8'h80, 32'h0844_9060, "R1 fn1 reset value");
        rd_chk(1'b0, 8'h84, 32'h0, "R1 other offset reads 0");
        check32("R3 pin codes at reset", {16'h0, int_pin}, 32'h0000_0201);
        check32("R7 no power-change request at reset", {29'h0, irq2_req, csc_req}, 32'h0);
        check32("R2 slots idle at reset", {28'h0, slot_irq}, 32'h0);
    endtask

    task automatic t_rotate;
        logic [3:0] pats [5] = '{4'h1, 4'h2, 4'h4, 4'h8, 4'h5};
        for (int s = 0; s < 4; s++) begin
            top_wr(1'b0, 8'(s << 6));
            for (int p = 0; p < 5; p++) begin
                slot_chk(pats[p], exp_slot(pats[p], s, 1'b0, 1'b0), $sformatf("R2 step %0d req %h", s, pats[p]));
            end
        end
        // R11: output waits for the next edge
        @(negedge clk); irq_req = 4'h0;
        @(negedge clk); irq_req = 4'h1;
        #1 check32("R11 slot unchanged before edge", {28'h0, slot_irq}, 32'h0);
        @(negedge clk);
        check32("R11 slot after one edge", {28'h0, slot_irq}, {28'h0, exp_slot(4'h1, 3, 1'b0, 1'b0)});
        top_wr(1'b0, 8'h00);
    endtask

    task automatic t_pair;
        top_wr(1'b0, 8'h20);
        slot_chk(4'h2, 4'h1, "R3 B merged into A");
        slot_chk(4'h4, 4'h4, "R3 C untouched");
        slot_chk(4'h8, 4'h8, "R3 D untouched");
        check32("R3 fn1 pin reports A", {16'h0, int_pin}, 32'h0000_0101);
        top_wr(1'b0, 8'h60);
        slot_chk(4'h2, exp_slot(4'h2, 1, 1'b1, 1'b0), "R3 merge then rotate by 1");
        top_wr(1'b0, 8'h00);
        check32("R3 fn1 pin back to B", {16'h0, int_pin}, 32'h0000_0201);
    endtask

    task automatic t_tieall;
        top_wr(1'b1, 8'h10);
        top_wr(1'b0, 8'h20);
        slot_chk(4'h8, 4'h1, "R4 D tied onto A, priority over pair tie");
        check32("R4 fn1 pin reports A", {16'h0, int_pin}, 32'h0000_0101);
        top_wr(1'b0, 8'hA0);
        slot_chk(4'h4, 4'h4, "R4 tie before rotation, A lands on slot C");
        slot_chk(4'h0, 4'h0, "R4 no request, no slot");
        top_wr(1'b1, 8'h00);
        top_wr(1'b0, 8'h00);
        check32("R4 pin back to B after untie", {16'h0, int_pin}, 32'h0000_0201);
    endtask

    task automatic t_shared;
        top_wr(1'b0, 8'h40);
        top_wr(1'b1, 8'hFF);
        rd_chk(1'b0, 8'h80, 32'h4044_9060, "R8 fn1 write leaves shared fields");
        rd_chk(1'b1, 8'h80, 32'h5844_9060, "R8 fn1 view: shared from fn0, own bits written");
        slot_chk(4'h4, 4'h2, "R8 step stays 1 while fn1 tie-all is set");
        top_wr(1'b1, 8'h00);
        top_wr(1'b0, 8'h00);
    endtask

    task automatic t_smi;
        pwr_pulse(2'b11);
        rd_chk(1'b0, 8'h80, 32'h0044_9060, "R5 strobe ignored while mode off");
        check32("R5 no request while mode off", {29'h0, irq2_req, csc_req}, 32'h0);
        top_wr(1'b0, 8'h01);
        pwr_pulse(2'b10);
        rd_chk(1'b1, 8'h80, 32'h0344_9060, "R5 socket 1 flag set");
        rd_chk(1'b0, 8'h80, 32'h0144_9060, "R5 socket 0 flag untouched");
        check32("R7 routed to IRQ2", {29'h0, irq2_req, csc_req}, 32'h4);
        top_wr(1'b0, 8'h05);
        check32("R7 routed to card-status-change 1", {29'h0, irq2_req, csc_req}, 32'h2);
        top_wr(1'b1, 8'h02);
        rd_chk(1'b1, 8'h80, 32'h0544_9060, "R6 write 1 clears flag");
        check32("R6 request drops with flag", {29'h0, irq2_req, csc_req}, 32'h0);
        pwr_pulse(2'b01);
        reg_wr(1'b0, 4'b1000, 32'h0700_0000, 2'b01);
        rd_chk(1'b0, 8'h80, 32'h0744_9060, "R6 set wins over same-cycle clear");
        check32("R7 socket 0 request held", {29'h0, irq2_req, csc_req}, 32'h1);
        top_wr(1'b0, 8'h05);
        rd_chk(1'b0, 8'h80, 32'h0744_9060, "R6 writing 0 leaves flag");
        top_wr(1'b0, 8'h07);
        rd_chk(1'b0, 8'h80, 32'h0544_9060, "R6 clear without strobe");
        check32("R7 no request after clear", {29'h0, irq2_req, csc_req}, 32'h0);
        top_wr(1'b0, 8'h00);
    endtask

    task automatic t_bytes;
        reg_wr(1'b0, 4'b0000, 32'hFFFF_FFFF, 2'b00);
        rd_chk(1'b0, 8'h80, 32'h0044_9060, "R10 no lanes enabled, no change");
        reg_wr(1'b0, 4'b0001, 32'hFFFF_FFFF, 2'b00);
        rd_chk(1'b0, 8'h80, 32'h0044_907B, "R10 low lane only, read-only bits 7,2 stay 0");
        reg_wr(1'b0, 4'b0110, 32'hFFFF_FFFF, 2'b00);
        rd_chk(1'b0, 8'h80, 32'h0074_D07B, "R10 middle lanes, bit 23 reads 0, bits 18 and 12 read 1");
        rd_chk(1'b1, 8'h80, 32'h0044_9060, "R10 other function untouched");
    endtask

    task automatic t_resets;
        top_wr(1'b0, 8'h15);
        rd_chk(1'b0, 8'h80, 32'h1574_D07B, "R9 before function reset");
        check32("R4 fn0 tie-all copy reported on fn1 pin", {16'h0, int_pin}, 32'h0000_0101);
        @(negedge clk); frst_n = 2'b10;
        @(negedge clk); frst_n = 2'b11;
        rd_chk(1'b0, 8'h80, 32'h1544_9060, "R9 function reset keeps upper byte");
        rd_chk(1'b1, 8'h80, 32'h0544_9060, "R9 other function unaffected");
        @(negedge clk); grst_n = 1'b0;
        @(negedge clk); grst_n = 1'b1;
        rd_chk(1'b0, 8'h80, 32'h0844_9060, "R9 global reset restores fn0");
        rd_chk(1'b1, 8'h80, 32'h0844_9060, "R9 global reset restores fn1");
        check32("R9 pins after global reset", {16'h0, int_pin}, 32'h0000_0201);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        grst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_rotate();
        t_pair();
        t_tieall();
        t_shared();
        t_smi();
        t_bytes();
        t_resets();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end
endmodule